// File: doc/BRIEF.md
# Multi-Die Chip-Enable and Operating-Mode Decoder

This block sits in front of a byte-wide memory module built from four identical dies. It turns the module's control pins into a one-hot, active-low select for each die, an operating-mode code, a data-output enable and a flag for forbidden enable combinations. It is purely combinational. The 21 low address bits are passed to every die unchanged.

Two addressing styles exist. In the unified style, a shared enable is driven low and all per-die enables stay high. The two top address bits then choose one die, so the module looks like one 8M x 8 memory. The mapping of those bits to dies is not binary: it follows a Gray-code order. In the individual style, the shared enable is high and one per-die enable is driven low. Each die is then a separate 2M x 8 memory addressed by the low 21 bits, and the top address bits are ignored. A high sleep/reset input overrides every other input.

Top module: `mcd_top`

## Requirements
- R1: With `ce_all_n` low and every `ce_n` bit high, `addr_hi` picks the die: 00 selects die 0, 01 die 1, 11 die 2 and 10 die 3. A selected die has its `die_sel_n` bit (bit index = die number) driven low.
- R2: With `ce_all_n` high and exactly one `ce_n` bit low, the die with that bit index is selected, whatever the value of `addr_hi`.
- R3: When two or more `ce_n` bits are low, `sel_illegal` is 1, every `die_sel_n` bit is 1 and `mode` is 1 (not selected).
- R4: When `ce_all_n` is low and any `ce_n` bit is low, `sel_illegal` is 1, every `die_sel_n` bit is 1 and `mode` is 1.
- R5: When `sleep_rst` is high, `mode` is 0 (sleep/reset), all `die_sel_n` bits are 1, and `sel_illegal` and `dout_en` are 0, whatever the other inputs are.
- R6: With `sleep_rst` low and no die selected, `mode` is 1 (not selected).
- R7: With a die selected and both `we_n` and `oe_n` high, `mode` is 2 (output disabled).
- R8: With a die selected, `we_n` high and `oe_n` low, `mode` is 3 (byte read).
- R9: With a die selected and `we_n` low, `mode` is 4 (byte write), whatever `oe_n` is.
- R10: `dout_en` is 1 exactly when `mode` is 3.
- R11: `die_addr` equals `addr_lo` in every mode.
- R12: At most one `die_sel_n` bit is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sleep_rst | input | 1 | High selects sleep/reset and overrides everything else |
| ce_all_n | input | 1 | Shared active-low enable for unified addressing |
| ce_n | input | 4 | Per-die active-low enables, bit i for die i |
| addr_hi | input | 2 | Top address bits, used only in unified addressing |
| addr_lo | input | 21 | Word address inside a die |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| die_sel_n | output | 4 | One-hot active-low die select, bit i for die i |
| die_addr | output | 21 | Address broadcast to all dies |
| mode | output | 3 | 0 sleep, 1 not selected, 2 output disabled, 3 read, 4 write |
| dout_en | output | 1 | Data-bus drive enable, high only for a read |
| sel_illegal | output | 1 | Forbidden enable combination was seen |

## Verification
The bench walks every combination of control pins and top address bits, each with a fresh random low address. The critical cases follow. The Gray-order pair 10/11 catches a plain binary decode, which would swap dies 2 and 3. A shared enable low together with one per-die enable low catches a design that lets either style win instead of flagging the conflict. Sleep with a forbidden enable pattern catches a design that raises the flag or keeps a die selected during sleep. Write with `oe_n` low catches a design that lets the read path drive the bus during a write.

// File: rtl/mcd_pkg.sv
`timescale 1ns/1ps
package mcd_pkg;

    localparam int NUM_DIES  = 4;
    localparam int LO_ADDR_W = 21;
    localparam int MODE_W    = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_SLEEP  = 3'd0,
        MODE_UNSEL  = 3'd1,
        MODE_OUTOFF = 3'd2,
        MODE_READ   = 3'd3,
        MODE_WRITE  = 3'd4
    } op_mode_e;

    // Unified addressing follows a Gray order: the die number is the
    // binary value of the Gray-coded top address bits.
    function automatic logic [$clog2(NUM_DIES)-1:0] gray_to_die(
        input logic [$clog2(NUM_DIES)-1:0] g
    );
        logic [$clog2(NUM_DIES)-1:0] b;
        b[$clog2(NUM_DIES)-1] = g[$clog2(NUM_DIES)-1];
        for (int i = $clog2(NUM_DIES) - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/mcd_die_select.sv
`timescale 1ns/1ps
module mcd_die_select
    import mcd_pkg::*;
#(
    parameter int DIES = NUM_DIES
) (
    input  logic                     ce_all_n,
    input  logic [DIES-1:0]          ce_n,
    input  logic [$clog2(DIES)-1:0]  addr_hi,
    output logic [DIES-1:0]          sel_n,
    output logic                     any_sel,
    output logic                     illegal
);
    localparam int HI_W  = $clog2(DIES);
    localparam int CNT_W = $clog2(DIES + 1);

    logic [CNT_W-1:0] ind_cnt;
    logic             unified;
    logic [HI_W-1:0]  uni_die;
    logic [DIES-1:0]  sel;

    always_comb begin
        ind_cnt = '0;
        for (int i = 0; i < DIES; i++) begin
            ind_cnt = ind_cnt + CNT_W'(~ce_n[i]);
        end
    end

    assign unified = ~ce_all_n;
    assign uni_die = gray_to_die(addr_hi);
    assign illegal = (ind_cnt > CNT_W'(1)) || (unified && (ind_cnt != '0));

    generate
        for (genvar d = 0; d < DIES; d++) begin : g_die
            logic hit_ind;
            logic hit_uni;
            assign hit_ind  = ce_all_n & ~ce_n[d];
            assign hit_uni  = unified & (uni_die == HI_W'(d));
            assign sel[d]   = ~illegal & (hit_ind | hit_uni);
            assign sel_n[d] = ~sel[d];
        end
    endgenerate

    assign any_sel = |sel;

endmodule

// File: rtl/mcd_mode_dec.sv
`timescale 1ns/1ps
module mcd_mode_dec
    import mcd_pkg::*;
(
    input  logic     sleep,
    input  logic     selected,
    input  logic     we_n,
    input  logic     oe_n,
    output op_mode_e mode,
    output logic     dout_en
);
    always_comb begin
        if (sleep) begin
            mode = MODE_SLEEP;
        end else if (!selected) begin
            mode = MODE_UNSEL;
        end else if (!we_n) begin
            mode = MODE_WRITE;
        end else if (!oe_n) begin
            mode = MODE_READ;
        end else begin
            mode = MODE_OUTOFF;
        end
    end

    // The bus is driven only for a read with a die selected and no sleep.
    assign dout_en = ~sleep & selected & we_n & ~oe_n;

endmodule

// File: rtl/mcd_top.sv
`timescale 1ns/1ps
module mcd_top
    import mcd_pkg::*;
#(
    parameter int DIES   = NUM_DIES,
    parameter int LO_W   = LO_ADDR_W
) (
    input  logic                    sleep_rst,
    input  logic                    ce_all_n,
    input  logic [DIES-1:0]         ce_n,
    input  logic [$clog2(DIES)-1:0] addr_hi,
    input  logic [LO_W-1:0]         addr_lo,
    input  logic                    we_n,
    input  logic                    oe_n,
    output logic [DIES-1:0]         die_sel_n,
    output logic [LO_W-1:0]         die_addr,
    output logic [MODE_W-1:0]       mode,
    output logic                    dout_en,
    output logic                    sel_illegal
);
    logic [DIES-1:0] raw_sel_n;
    logic            raw_any;
    logic            raw_illegal;
    op_mode_e        mode_e;

    mcd_die_select #(.DIES(DIES)) u_sel (
        .ce_all_n (ce_all_n),
        .ce_n     (ce_n),
        .addr_hi  (addr_hi),
        .sel_n    (raw_sel_n),
        .any_sel  (raw_any),
        .illegal  (raw_illegal)
    );

    mcd_mode_dec u_mode (
        .sleep    (sleep_rst),
        .selected (raw_any),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .mode     (mode_e),
        .dout_en  (dout_en)
    );

    // Sleep parks every die and hides the enable check.
    assign die_sel_n   = sleep_rst ? '1 : raw_sel_n;
    assign sel_illegal = ~sleep_rst & raw_illegal;
    assign die_addr    = addr_lo;
    assign mode        = mode_e;

endmodule

// File: rtl/mcd_checker.sv
`timescale 1ns/1ps
module mcd_checker
    import mcd_pkg::*;
#(
    parameter int DIES = NUM_DIES,
    parameter int LO_W = LO_ADDR_W
) (
    input logic                    sleep_rst,
    input logic                    ce_all_n,
    input logic [DIES-1:0]         ce_n,
    input logic [LO_W-1:0]         addr_lo,
    input logic                    we_n,
    input logic [DIES-1:0]         die_sel_n,
    input logic [LO_W-1:0]         die_addr,
    input logic [MODE_W-1:0]       mode,
    input logic                    dout_en,
    input logic                    sel_illegal
);
    always_comb begin
        p_onehot_sel_r12: assert ($countones(~die_sel_n) <= 1)
            else $error("more than one die selected");
        p_sleep_parks_r5: assert (!sleep_rst || (die_sel_n == '1 && !sel_illegal && !dout_en))
            else $error("sleep did not park the dies");
        p_illegal_desel_r3: assert (!sel_illegal || (die_sel_n == '1 && mode == MODE_W'(MODE_UNSEL)))
            else $error("illegal pattern left a die selected");
        p_mixed_illegal_r4: assert (sleep_rst || ce_all_n || ce_n == '1 || sel_illegal)
            else $error("shared plus individual enable not flagged");
        p_dout_read_r10: assert (dout_en == (mode == MODE_W'(MODE_READ)))
            else $error("data enable disagrees with mode");
        p_write_mode_r9: assert (sleep_rst || we_n || die_sel_n == '1 || mode == MODE_W'(MODE_WRITE))
            else $error("write not decoded");
        p_addr_pass_r11: assert (die_addr == addr_lo)
            else $error("low address altered");
    end
endmodule

bind mcd_top mcd_checker #(.DIES(DIES), .LO_W(LO_W)) u_chk (
    .sleep_rst   (sleep_rst),
    .ce_all_n    (ce_all_n),
    .ce_n        (ce_n),
    .addr_lo     (addr_lo),
    .we_n        (we_n),
    .die_sel_n   (die_sel_n),
    .die_addr    (die_addr),
    .mode        (mode),
    .dout_en     (dout_en),
    .sel_illegal (sel_illegal)
);

// File: tb/mcd_top_bench.sv
`timescale 1ns/1ps
module mcd_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sleep_rst;
    logic        ce_all_n;
    logic [3:0]  ce_n;
    logic [1:0]  addr_hi;
    logic [20:0] addr_lo;
    logic        we_n;
    logic        oe_n;
    logic [3:0]  die_sel_n;
    logic [20:0] die_addr;
    logic [2:0]  mode;
    logic        dout_en;
    logic        sel_illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    mcd_top u_mcd_top (
        .sleep_rst   (sleep_rst),
        .ce_all_n    (ce_all_n),
        .ce_n        (ce_n),
        .addr_hi     (addr_hi),
        .addr_lo     (addr_lo),
        .we_n        (we_n),
        .oe_n        (oe_n),
        .die_sel_n   (die_sel_n),
        .die_addr    (die_addr),
        .mode        (mode),
        .dout_en     (dout_en),
        .sel_illegal (sel_illegal)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (sl=%0b all=%0b ce=%b hi=%b we=%0b oe=%0b)",
                     req, act, exp, sleep_rst, ce_all_n, ce_n, addr_hi, we_n, oe_n);
        end
    endtask

    // Behavioural reference: returns expected select, mode, enable and flag.
    task automatic model(output int e_sel, output int e_mode, output int e_dout,
                         output int e_ill, output string req);
        int lows = 0;
        int die  = -1;
        for (int i = 0; i < 4; i++) if (!ce_n[i]) begin lows++; die = i; end
        e_sel = 15; e_ill = 0; e_dout = 0;
        if (sleep_rst) begin
            e_mode = 0; req = "R5";
            return;
        end
        if (lows > 1) begin
            e_ill = 1; req = "R3"; die = -1;
        end else if (!ce_all_n && lows == 1) begin
            e_ill = 1; req = "R4"; die = -1;
        end else if (!ce_all_n) begin
            case (addr_hi)
                2'b00: die = 0;
                2'b01: die = 1;
                2'b11: die = 2;
                default: die = 3;
            endcase
            req = "R1";
        end else if (lows == 1) begin
            req = "R2";
        end else begin
            req = "R6"; die = -1;
        end
        if (die < 0) begin
            e_mode = 1;
        end else begin
            e_sel = 15 & ~(1 << die);
            if (!we_n) e_mode = 4;
            else if (!oe_n) e_mode = 3;
            else e_mode = 2;
            e_dout = (e_mode == 3) ? 1 : 0;
        end
    endtask

    task automatic apply_and_check(input logic [9:0] v);
        int es, em, ed, ei;
        string rq;
        @(negedge clk);
        {sleep_rst, ce_all_n, ce_n, addr_hi, we_n, oe_n} = v;
        addr_lo = 21'($urandom);
        #5;
        model(es, em, ed, ei, rq);
        check({rq, " select"}, int'(die_sel_n), es);
        if (em >= 2) begin
            if (em == 2)      check("R7 mode", int'(mode), em);
            else if (em == 3) check("R8 mode", int'(mode), em);
            else              check("R9 mode", int'(mode), em);
        end else begin
            check({rq, " mode"}, int'(mode), em);
        end
        check("R10 dout_en", int'(dout_en), ed);
        check({rq, " illegal"}, int'(sel_illegal), ei);
        check("R11 addr", int'(die_addr), int'(addr_lo));
        check("R12 onehot", int'($countones(~die_sel_n) <= 1), 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        sleep_rst = 1'b1; ce_all_n = 1'b1; ce_n = 4'hF; addr_hi = 2'b00;
        addr_lo = '0; we_n = 1'b1; oe_n = 1'b1;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk); #5;
        // reset state: sleep held high from the start
        check("R5 reset mode", int'(mode), 0);
        check("R5 reset select", int'(die_sel_n), 15);
        // R1 Gray corner: 10 -> die 3, 11 -> die 2
        apply_and_check(10'b0_0_1111_10_1_0);
        apply_and_check(10'b0_0_1111_11_1_0);
        // R9 write with output enable low
        apply_and_check(10'b0_1_1011_00_0_0);
        // R5 sleep over an illegal pattern
        apply_and_check(10'b1_0_0000_01_1_0);
        for (int v = 0; v < 1024; v++) apply_and_check(10'(v));
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule